// File: doc/BRIEF.md
# Glitch-Free Audio Master Clock Selector

This block picks the master audio clock from one of two free-running sources: a clock recovered by a PLL and a reference clock from a crystal. The choice follows the PLL lock state on its own. A force control pins the choice to the reference clock, and a PLL-stop control does the same. The block divides the selected clock down to a 64 fs bit clock and an fs frame clock. The ratio between master clock and fs is set by a two-bit ratio code.

A change of source never cuts a clock pulse short. Each source has its own gate. The enable of each gate is resynchronised in that source's domain by two flops and changes only while that source is low. The gate of the new source opens only after the gate of the old source has closed. A small state machine in the reference domain tracks the switch and raises a busy flag for its whole duration. Its states are ST_REF (reference settled), ST_TO_PLL (moving to PLL), ST_PLL (PLL settled) and ST_TO_REF (moving to reference). It moves as follows:
- ST_REF to ST_TO_PLL when the synchronised PLL request rises.
- ST_TO_PLL to ST_PLL when the PLL gate is seen open and the reference gate is closed.
- ST_PLL to ST_TO_REF when the request falls.
- ST_TO_REF to ST_REF when the reference gate is open and the PLL gate is seen closed.
- ST_TO_PLL and ST_TO_REF cross directly to each other if the request reverses part way through a switch.

Only the system reset clears the dividers. Their phase therefore carries across a source switch.

Top module: `audio_clk_select`

## Requirements
- R1: When force_ref and pll_stop are 0, the master clock comes from clk_pll while pll_locked is 1 and from clk_ref while pll_locked is 0.
- R2: When force_ref is 1, or when pll_stop is 1, the master clock comes from clk_ref whatever the state of pll_locked.
- R3: A PLL request made while the PLL is unlocked stays pending. Once pll_locked rises, the source moves to clk_pll with no further change to any control.
- R4: The two source gates are never open together. No high or low pulse on mclk is shorter than half a period of the faster source.
- R5: ratio_sel codes 0, 1 and 2 select multiples of 256, 384 and 512 fs. The bit clock period is (multiple/64) core periods and the frame clock period is (multiple) core periods, where the core clock is the selected source.
- R6: ratio_sel code 3 runs the core clock at half the selected source and uses the 256 fs divide ratios. This matches a 512 fs lock with a 256 fs master clock.
- R7: When half_rate is 1, the mclk period doubles. The bclk and lrclk periods do not change.
- R8: When fmt_biphase is 1 and clk_pll is the source, the bit clock divide is halved (128 fs). While clk_ref is the source, the bit clock stays at 64 fs.
- R9: switching goes to 1 within a few clk_ref cycles after the source request changes. It returns to 0 once the new gate is open, and then exactly one gate is open.
- R10: While rst_n is 0, bclk, lrclk and switching are 0 and mclk runs from clk_ref.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll | input | 1 | Recovered PLL clock |
| clk_ref | input | 1 | Reference crystal clock; also clocks the switch controller |
| rst_n | input | 1 | Asynchronous active-low system reset |
| pll_locked | input | 1 | PLL lock flag |
| pll_stop | input | 1 | PLL stopped; forces the reference source |
| force_ref | input | 1 | Force the reference source |
| ratio_sel | input | 2 | Master clock multiple: 0=256, 1=384, 2=512, 3=512 lock output halved |
| half_rate | input | 1 | Halve the mclk output |
| fmt_biphase | input | 1 | Bi-phase output format active |
| mclk | output | 1 | Master clock |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame clock |
| switching | output | 1 | Source switch in progress |

## Verification
The assertions check on every reference cycle that the two gates are never open together. They also check that each settled state of the controller matches the gates that are actually open, and that exactly one gate is open whenever the busy flag is low.

Some behaviours only the bench scenarios can show:
- Which source ends up selected, seen as the measured mclk period.
- The absence of short pulses across repeated lock, force and stop changes.
- The pending PLL request that completes on lock.
- The divide ratios of bclk and lrclk for every ratio code, half-rate and bi-phase setting.

// File: rtl/clk_sel_pkg.sv
`timescale 1ns/1ps
package clk_sel_pkg;

    // Switch controller states, held in the reference clock domain
    typedef enum logic [1:0] {
        ST_REF    = 2'd0,
        ST_TO_PLL = 2'd1,
        ST_PLL    = 2'd2,
        ST_TO_REF = 2'd3
    } sw_state_e;

    // Master clock multiple codes
    typedef enum logic [1:0] {
        RATIO_256      = 2'd0,
        RATIO_384      = 2'd1,
        RATIO_512      = 2'd2,
        RATIO_512_HALF = 2'd3
    } ratio_e;

endpackage

// File: rtl/clk_gate_lane.sv
`timescale 1ns/1ps
// One source lane: the request is resynchronised in the source domain and the
// enable is updated on the falling edge only, so the gated clock never gets
// a shortened high phase.
module clk_gate_lane #(
    parameter bit RST_ON = 1'b0
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic req,
    input  logic other_en,
    output logic en,
    output logic gclk
);
    logic s1, s2;

    // Open only once the other lane is closed (R4)
    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= RST_ON;
            s2 <= RST_ON;
        end else begin
            s1 <= req & ~other_en;
            s2 <= s1;
        end
    end

    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) en <= RST_ON;
        else        en <= s2;
    end

    assign gclk = clk_src & en;
endmodule

// File: rtl/clk_switch_fsm.sv
`timescale 1ns/1ps
module clk_switch_fsm
    import clk_sel_pkg::*;
(
    input  logic clk_ref,
    input  logic rst_n,
    input  logic want_raw,
    input  logic ref_en,
    input  logic pll_en,
    output logic want_s,
    output logic switching
);
    logic w1, w2, p1, p2;
    sw_state_e state, state_nx;

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            w1 <= 1'b0;
            w2 <= 1'b0;
            p1 <= 1'b0;
            p2 <= 1'b0;
        end else begin
            w1 <= want_raw;
            w2 <= w1;
            p1 <= pll_en;
            p2 <= p1;
        end
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) state <= ST_REF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_REF:    if (w2) state_nx = ST_TO_PLL;
            ST_TO_PLL: begin
                if (!w2)                state_nx = ST_TO_REF;
                else if (p2 && !ref_en) state_nx = ST_PLL;
            end
            ST_PLL:    if (!w2) state_nx = ST_TO_REF;
            ST_TO_REF: begin
                if (w2)                 state_nx = ST_TO_PLL;
                else if (ref_en && !p2) state_nx = ST_REF;
            end
            default:   state_nx = ST_REF;
        endcase
    end

    // Outputs
    always_comb begin
        want_s    = w2;
        switching = (state == ST_TO_PLL) || (state == ST_TO_REF);
    end

    // R1: settled on the reference, only the reference gate is open
    p_ref_settled_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state == ST_REF) |-> (ref_en && !p2));
    // R3: settled on the PLL, only the PLL gate is open
    p_pll_settled_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state == ST_PLL) |-> (p2 && !ref_en));
    // R9: busy flag low means exactly one gate open
    p_idle_one_source_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !switching |-> (ref_en != p2));
endmodule

// File: rtl/clk_frame_div.sv
`timescale 1ns/1ps
module clk_frame_div #(
    parameter int MULT_LO   = 256,
    parameter int MULT_MID  = 384,
    parameter int MULT_HI   = 512,
    parameter int BCLK_MULT = 64
) (
    input  logic       clk_core,
    input  logic       rst_n,
    input  logic [1:0] ratio_sel,
    input  logic       fast_bclk,
    output logic       bclk,
    output logic       lrclk
);
    localparam int CW = $clog2(MULT_HI) + 1;

    logic [CW-1:0] m_w, d_w, bcnt, fcnt, bnx, fnx;

    // R5/R6: divide ratios from the master clock multiple
    always_comb begin
        unique case (ratio_sel)
            2'd1:    m_w = CW'(MULT_MID);
            2'd2:    m_w = CW'(MULT_HI);
            default: m_w = CW'(MULT_LO);
        endcase
        d_w = m_w / CW'(BCLK_MULT);
        if (fast_bclk) d_w = d_w >> 1;   // R8
        bnx = (bcnt >= d_w - 1'b1) ? '0 : bcnt + 1'b1;
        fnx = (fcnt >= m_w - 1'b1) ? '0 : fcnt + 1'b1;
    end

    // Cleared only by the system reset, never by a source switch
    always_ff @(posedge clk_core or negedge rst_n) begin
        if (!rst_n) begin
            bcnt  <= '0;
            fcnt  <= '0;
            bclk  <= 1'b0;
            lrclk <= 1'b0;
        end else begin
            bcnt  <= bnx;
            fcnt  <= fnx;
            bclk  <= (bnx >= (d_w >> 1));
            lrclk <= (fnx >= (m_w >> 1));
        end
    end
endmodule

// File: rtl/audio_clk_select.sv
`timescale 1ns/1ps
module audio_clk_select #(
    parameter int MULT_LO   = 256,
    parameter int MULT_MID  = 384,
    parameter int MULT_HI   = 512,
    parameter int BCLK_MULT = 64
) (
    input  logic       clk_pll,
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic       pll_locked,
    input  logic       pll_stop,
    input  logic       force_ref,
    input  logic [1:0] ratio_sel,
    input  logic       half_rate,
    input  logic       fmt_biphase,
    output logic       mclk,
    output logic       bclk,
    output logic       lrclk,
    output logic       switching
);
    import clk_sel_pkg::*;

    logic want_raw, want_s;
    logic en_ref, en_pll, gclk_ref, gclk_pll;
    logic mux_clk, core_clk, div2_q, half_q, fast_s1, fast_s2;

    // R1/R2: PLL only when locked, not forced and not stopped
    assign want_raw = pll_locked & ~force_ref & ~pll_stop;

    clk_switch_fsm i_fsm (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .want_raw  (want_raw),
        .ref_en    (en_ref),
        .pll_en    (en_pll),
        .want_s    (want_s),
        .switching (switching)
    );

    clk_gate_lane #(.RST_ON(1'b1)) i_lane_ref (
        .clk_src  (clk_ref),
        .rst_n    (rst_n),
        .req      (~want_s),
        .other_en (en_pll),
        .en       (en_ref),
        .gclk     (gclk_ref)
    );

    clk_gate_lane #(.RST_ON(1'b0)) i_lane_pll (
        .clk_src  (clk_pll),
        .rst_n    (rst_n),
        .req      (want_s),
        .other_en (en_ref),
        .en       (en_pll),
        .gclk     (gclk_pll)
    );

    assign mux_clk = gclk_ref | gclk_pll;

    // R6: the 512 fs lock code runs the core at half rate
    always_ff @(posedge mux_clk or negedge rst_n) begin
        if (!rst_n) div2_q <= 1'b0;
        else        div2_q <= ~div2_q;
    end
    assign core_clk = (ratio_e'(ratio_sel) == RATIO_512_HALF) ? div2_q : mux_clk;

    // R7: half-rate acts on the master clock output only
    always_ff @(posedge core_clk or negedge rst_n) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= ~half_q;
    end
    assign mclk = half_rate ? half_q : core_clk;

    // R8: bi-phase doubling only while the PLL gate is open
    always_ff @(posedge core_clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_s1 <= 1'b0;
            fast_s2 <= 1'b0;
        end else begin
            fast_s1 <= fmt_biphase & en_pll;
            fast_s2 <= fast_s1;
        end
    end

    clk_frame_div #(
        .MULT_LO   (MULT_LO),
        .MULT_MID  (MULT_MID),
        .MULT_HI   (MULT_HI),
        .BCLK_MULT (BCLK_MULT)
    ) i_div (
        .clk_core  (core_clk),
        .rst_n     (rst_n),
        .ratio_sel (ratio_sel),
        .fast_bclk (fast_s2),
        .bclk      (bclk),
        .lrclk     (lrclk)
    );

    // R4: the two gates are never open together
    p_exclusive_gates_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !(en_ref && en_pll));
endmodule

// File: tb/test_audio_clk_select.sv
`timescale 1ns/1ps
module test_audio_clk_select;
    logic clk_pll = 1'b0, clk_ref = 1'b0, rst_n = 1'b0;
    logic pll_locked = 1'b0, pll_stop = 1'b0, force_ref = 1'b0;
    logic [1:0] ratio_sel = 2'd0;
    logic half_rate = 1'b0, fmt_biphase = 1'b0;
    logic mclk, bclk, lrclk, switching;

    int vectors = 0, miscompares = 0;
    bit mon_on = 1'b0, have_last = 1'b0;
    realtime last_t = 0.0, min_w = 1.0e9;

    always #5 clk_ref = ~clk_ref;   // 100 MHz reference
    always #3 clk_pll = ~clk_pll;   // recovered clock, 6 ns

    audio_clk_select i_audio_clk_select (
        .clk_pll(clk_pll), .clk_ref(clk_ref), .rst_n(rst_n),
        .pll_locked(pll_locked), .pll_stop(pll_stop), .force_ref(force_ref),
        .ratio_sel(ratio_sel), .half_rate(half_rate), .fmt_biphase(fmt_biphase),
        .mclk(mclk), .bclk(bclk), .lrclk(lrclk), .switching(switching)
    );

    // Narrowest mclk pulse while the monitor is armed (R4)
    always @(mclk) begin
        if (mon_on && have_last && ($realtime - last_t < min_w))
            min_w = $realtime - last_t;
        last_t    = $realtime;
        have_last = mon_on;
    end

    function automatic bit exp_pll(bit l, bit f, bit s);
        return l & !f & !s;
    endfunction
    function automatic int exp_mult(logic [1:0] r);
        case (r)
            2'd1:    return 384;
            2'd2:    return 512;
            default: return 256;
        endcase
    endfunction
    function automatic real exp_core(bit p, logic [1:0] r);
        real base = p ? 6.0 : 10.0;
        return (r == 2'd3) ? 2.0 * base : base;
    endfunction

    task automatic chk(string tag, string what, real act, real exp);
        vectors++;
        if (act - exp > 0.01 || exp - act > 0.01) begin
            miscompares++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", tag, what, act, exp);
        end
    endtask

    task automatic period_of(int sel, output real p);
        realtime t0;
        case (sel)
            0: begin @(posedge mclk);  t0 = $realtime; @(posedge mclk);  end
            1: begin @(posedge bclk);  t0 = $realtime; @(posedge bclk);  end
            default: begin @(posedge lrclk); t0 = $realtime; @(posedge lrclk); end
        endcase
        p = $realtime - t0;
    endtask

    task automatic settle();
        repeat (60) @(posedge clk_ref);
    endtask

    task automatic apply_check(string tag, bit l, bit f, bit s, logic [1:0] r,
                               bit h, bit b);
        real p, core;
        bit pl;
        @(negedge clk_ref);
        pll_locked = l; force_ref = f; pll_stop = s;
        ratio_sel = r; half_rate = h; fmt_biphase = b;
        settle();
        period_of(2, p);
        pl   = exp_pll(l, f, s);
        core = exp_core(pl, r);
        period_of(0, p);
        chk(tag, "mclk period", p, h ? 2.0 * core : core);
        period_of(1, p);
        chk(tag, "bclk period", p,
            core * real'(exp_mult(r) / 64) / ((b && pl) ? 2.0 : 1.0));
        period_of(2, p);
        chk(tag, "lrclk period", p, core * real'(exp_mult(r)));
    endtask

    task automatic src_check(string tag, real exp_period);
        real p;
        settle();
        @(negedge clk_ref);
        chk(tag, "switching idle", real'(switching), 0.0);
        period_of(0, p);
        chk(tag, "mclk period", p, exp_period);
    endtask

    initial begin : watchdog
        #1_500_000;
        miscompares++;
        $display("FAIL watchdog expired: actual time %0t expected finish earlier", $time);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        real p;
        void'($urandom(32'd20231));

        // R10: state held in reset
        repeat (5) @(posedge clk_ref);
        @(negedge clk_ref);
        chk("R10", "bclk in reset", real'(bclk), 0.0);
        chk("R10", "lrclk in reset", real'(lrclk), 0.0);
        chk("R10", "switching in reset", real'(switching), 0.0);
        period_of(0, p);
        chk("R10", "mclk period in reset", p, 10.0);
        @(negedge clk_ref);
        rst_n = 1'b1;

        // R1 unlocked -> ref; R3 pending PLL request completes on lock; R9 flag
        src_check("R1", 10.0);
        mon_on = 1'b1;
        @(negedge clk_ref);
        pll_locked = 1'b1;
        repeat (5) @(posedge clk_ref);
        @(negedge clk_ref);
        chk("R9", "switching during switch", real'(switching), 1.0);
        src_check("R3", 6.0);
        @(negedge clk_ref); force_ref = 1'b1;  src_check("R2", 10.0);
        @(negedge clk_ref); force_ref = 1'b0;  src_check("R1", 6.0);
        @(negedge clk_ref); pll_stop = 1'b1;   src_check("R2", 10.0);
        @(negedge clk_ref); pll_stop = 1'b0;   src_check("R9", 6.0);
        @(negedge clk_ref); pll_locked = 1'b0; src_check("R1", 10.0);
        mon_on = 1'b0;
        chk("R4", "narrowest mclk pulse", (min_w >= 2.99) ? 3.0 : min_w, 3.0);

        // Directed ratio, half-rate and bi-phase corners
        apply_check("R5", 1'b1, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0);
        apply_check("R6", 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0);
        apply_check("R7", 1'b1, 1'b0, 1'b0, 2'd3, 1'b1, 1'b0);
        apply_check("R8", 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1);
        apply_check("R8", 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1);

        // Constrained random mix
        for (int i = 0; i < 12; i++) begin
            apply_check("R5", 1'($urandom_range(1, 0)), 1'($urandom_range(3, 0) == 0),
                        1'($urandom_range(3, 0) == 0), 2'($urandom_range(3, 0)),
                        1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule